// File: doc/BRIEF.md
# Branch and Stack Sequencer

This block owns a processor's 16-bit program counter and its 16-bit stack pointer. It carries out every change of control flow: jumps, subroutine calls, returns, restarts and the load of the program counter from the HL register pair. A jump, call or return can run unconditionally or be gated by one of eight flag tests. When a call or restart is taken, the block saves the return address in a small byte-wide stack memory that it holds itself. When a return is taken, it reads that address back from the same memory.

The decoder presents an operation code, a condition enable, a 3-bit condition selector, the four flags, a 16-bit target and the HL pair. It then pulses `start` for one clock. The block works through its stack bytes one per clock and updates the program counter. It then raises `done` for exactly one clock. A restart takes its vector number from the condition selector field. Fetch, the arithmetic unit and the external bus are handled elsewhere.

Top module: `flow_ctl`

## Requirements
- R1: While `rst_n` is low at a rising edge, `pc` becomes 0000h, `sp` becomes 0000h and `done` goes low.
- R2: The `cond_sel` values map to tests as follows: 000 is Z=0, 001 is Z=1, 010 is CY=0, 011 is CY=1, 100 is P=0, 101 is P=1, 110 is S=0 and 111 is S=1. The test is applied only when `cond_en` is high; when `cond_en` is low the operation is always taken. The `op` codes are 000 jump, 001 call, 010 return, 011 restart and 100 load from HL.
- R3: A taken jump loads `pc` with `target`. A jump that is not taken sets `pc` to `pc`+3. Either way, `pc` changes and `done` rises at the first edge after `start` is sampled.
- R4: A taken call stores the return address `pc`+3, high byte first, at `sp`-1. It then stores the low byte at `sp`-2. It lowers `sp` by 2 and loads `pc` with `target`. This happens at the third edge after `start`, and `done` rises at that same edge.
- R5: A taken return reads the low byte at `sp` and the high byte at `sp`+1. It loads `pc` with those two bytes and raises `sp` by 2, at the third edge after `start`. A return that is not taken sets `pc` to `pc`+1 and leaves `sp` unchanged, at the first edge.
- R6: Restart n, where n is `cond_sel`, is always taken. It pushes `pc`+1 in the same way as a call and loads `pc` with 8×n, from 0000h up to 0038h, at the third edge.
- R7: The load from HL places `hl[15:8]` in the high byte of `pc` and `hl[7:0]` in the low byte, at the first edge.
- R8: A call that is not taken sets `pc` to `pc`+3, leaves `sp` unchanged, stores nothing and finishes at the first edge.
- R9: `done` is high for exactly one clock per accepted operation. The block ignores `start` while an operation is in progress and during its `done` clock.
- R10: `op` codes 101, 110 and 111 leave `pc` and `sp` unchanged and still give one `done` pulse, at the first edge.
- R11: The stack memory holds 32 bytes, addressed by the low 5 bits of `sp`. At least 15 nested calls return in last-in, first-out order to their correct return addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin the presented operation |
| op | input | 3 | Operation code |
| cond_en | input | 1 | Gate the operation with the flag test |
| cond_sel | input | 3 | Flag test selector; restart number for restarts |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| flag_p | input | 1 | Parity flag |
| flag_cy | input | 1 | Carry flag |
| target | input | 16 | Destination address for jumps and calls |
| hl | input | 16 | HL register pair |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| done | output | 1 | One-clock completion pulse |

## Verification
Two events can land in the same clock: a new `start` request, and the final stack write or the completion pulse of an operation already running. To provoke this, the bench holds `start` high through an entire call, including its `done` clock. It then confirms that the call completes only once, that no second `done` appears, and that `pc` and `sp` match a single operation. A second overlap is a return issued straight after a call. In that case the pop reads the bytes written in the clocks just before it. This overlap is judged by comparing the popped address with the bench's own stack model, including a run of 15 nested calls.

// File: rtl/flow_pkg.sv
// Shared constants and types for the branch and stack sequencer.
// Assumes a 16-bit address space built from two address bytes.
package flow_pkg;

    localparam int ADDR_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int RST_SHIFT = 3;

    localparam logic [2:0] OP_JMP  = 3'd0;
    localparam logic [2:0] OP_CALL = 3'd1;
    localparam logic [2:0] OP_RET  = 3'd2;
    localparam logic [2:0] OP_RST  = 3'd3;
    localparam logic [2:0] OP_PCHL = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_HI = 3'd1,
        ST_PUSH_LO = 3'd2,
        ST_POP_LO  = 3'd3,
        ST_POP_HI  = 3'd4,
        ST_FINISH  = 3'd5
    } flow_state_e;

endpackage

// File: rtl/flow_cond.sv
// Flag test evaluator. The two upper selector bits pick a flag
// (0 zero, 1 carry, 2 parity, 3 sign) and the lowest bit gives the
// value that flag must hold for the test to pass.
// Assumes the flags are stable while the request is sampled.
module flow_cond (
    input  logic [2:0] cond_sel,
    input  logic       flag_s,
    input  logic       flag_z,
    input  logic       flag_p,
    input  logic       flag_cy,
    output logic       cond_ok
);

    logic [3:0] flag_vec;
    logic [7:0] test_vec;

    // Order flags so that the selector's upper bits index them directly.
    assign flag_vec = {flag_s, flag_p, flag_cy, flag_z};

    // One comparator per selector value.
    for (genvar k = 0; k < 8; k++) begin : g_test
        assign test_vec[k] = (flag_vec[k / 2] == ((k % 2) == 1));
    end

    // Pick the requested test.
    assign cond_ok = test_vec[cond_sel];

endmodule

// File: rtl/flow_target.sv
// Address planner: from the operation, flag test and current PC it
// works out the PC for a single-step finish, the return address to
// save, the destination after a push, and whether stack work is needed.
// Purely combinational; assumes inputs are held while start is sampled.
module flow_target
    import flow_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [2:0]    op,
    input  logic          cond_en,
    input  logic          cond_ok,
    input  logic [2:0]    cond_sel,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] target,
    input  logic [AW-1:0] hl,
    output logic [AW-1:0] next_pc,
    output logic [AW-1:0] link,
    output logic [AW-1:0] dest,
    output logic          need_push,
    output logic          need_pop
);

    localparam int VEC_W = 3 + RST_SHIFT;

    logic          gate;
    logic          long_op;
    logic [AW-1:0] fall;
    logic [AW-1:0] vec_addr;

    // Condition gate, instruction length and restart vector.
    always_comb begin
        gate     = !cond_en || cond_ok;
        long_op  = (op == OP_JMP) || (op == OP_CALL);
        fall     = pc + (long_op ? AW'(3) : AW'(1));
        vec_addr = {{(AW-VEC_W){1'b0}}, cond_sel, {RST_SHIFT{1'b0}}};
    end

    // Per-operation plan.
    always_comb begin
        next_pc   = pc;
        link      = fall;
        dest      = target;
        need_push = 1'b0;
        need_pop  = 1'b0;
        case (op)
            OP_JMP:  next_pc = gate ? target : fall;
            OP_CALL: begin
                next_pc   = fall;
                need_push = gate;
            end
            OP_RET: begin
                next_pc  = fall;
                need_pop = gate;
            end
            OP_RST: begin
                dest      = vec_addr;
                need_push = 1'b1;
            end
            OP_PCHL: next_pc = hl;
            default: next_pc = pc;
        endcase
    end

endmodule

// File: rtl/flow_stack.sv
// Byte-wide stack storage: one synchronous write port and one
// combinational read port. Assumes the controller never reads and
// writes the same entry in the same clock.
module flow_stack #(
    parameter int IDX_W = 5,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [DW-1:0]    rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0] mem [DEPTH];

    // Store one byte when written.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the addressed byte.
    assign rdata = mem[raddr];

endmodule

// File: rtl/flow_ctl.sv
// Branch and stack sequencer top. Holds the PC and SP and runs
// jump, call, return, restart and load-from-HL operations, spending
// one clock per stack byte and then pulsing done for one clock.
// Assumes request inputs are valid in the cycle start is high.
module flow_ctl
    import flow_pkg::*;
#(
    parameter int          STACK_IDX_W = 5,
    parameter logic [15:0] PC_INIT     = 16'h0000,
    parameter logic [15:0] SP_INIT     = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [2:0]  op,
    input  logic        cond_en,
    input  logic [2:0]  cond_sel,
    input  logic        flag_s,
    input  logic        flag_z,
    input  logic        flag_p,
    input  logic        flag_cy,
    input  logic [15:0] target,
    input  logic [15:0] hl,
    output logic [15:0] pc,
    output logic [15:0] sp,
    output logic        done
);

    localparam int AW = ADDR_W;
    localparam int BW = BYTE_W;

    flow_state_e   state_q;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] sp_q;
    logic [AW-1:0] link_q;
    logic [AW-1:0] dest_q;
    logic [AW-1:0] sp_dec;
    logic [AW-1:0] sp_inc;

    logic          cond_ok;
    logic [AW-1:0] next_pc;
    logic [AW-1:0] link;
    logic [AW-1:0] dest;
    logic          need_push;
    logic          need_pop;
    logic          busy;
    logic          accept;

    logic          st_we;
    logic [BW-1:0] st_wdata;
    logic [BW-1:0] st_rdata;

    flow_cond u_cond (
        .cond_sel (cond_sel),
        .flag_s   (flag_s),
        .flag_z   (flag_z),
        .flag_p   (flag_p),
        .flag_cy  (flag_cy),
        .cond_ok  (cond_ok)
    );

    flow_target #(.AW(AW)) u_target (
        .op        (op),
        .cond_en   (cond_en),
        .cond_ok   (cond_ok),
        .cond_sel  (cond_sel),
        .pc        (pc_q),
        .target    (target),
        .hl        (hl),
        .next_pc   (next_pc),
        .link      (link),
        .dest      (dest),
        .need_push (need_push),
        .need_pop  (need_pop)
    );

    // Stack pointer neighbours and request acceptance.
    always_comb begin
        sp_dec = sp_q - AW'(1);
        sp_inc = sp_q + AW'(1);
        busy   = (state_q != ST_IDLE);
        accept = start && !busy;
    end

    // Write strobe and byte for the two push phases.
    always_comb begin
        st_we    = (state_q == ST_PUSH_HI) || (state_q == ST_PUSH_LO);
        st_wdata = (state_q == ST_PUSH_HI) ? link_q[AW-1:BW] : link_q[BW-1:0];
    end

    flow_stack #(.IDX_W(STACK_IDX_W), .DW(BW)) u_stack (
        .clk   (clk),
        .we    (st_we),
        .waddr (sp_dec[STACK_IDX_W-1:0]),
        .wdata (st_wdata),
        .raddr (sp_q[STACK_IDX_W-1:0]),
        .rdata (st_rdata)
    );

    // Sequencer: accept, push or pop byte by byte, then finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= PC_INIT;
            sp_q    <= SP_INIT;
            link_q  <= '0;
            dest_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (need_push) begin
                            link_q  <= link;
                            dest_q  <= dest;
                            state_q <= ST_PUSH_HI;
                        end else if (need_pop) begin
                            state_q <= ST_POP_LO;
                        end else begin
                            pc_q    <= next_pc;
                            state_q <= ST_FINISH;
                        end
                    end
                end
                ST_PUSH_HI: begin
                    sp_q    <= sp_dec;
                    state_q <= ST_PUSH_LO;
                end
                ST_PUSH_LO: begin
                    sp_q    <= sp_dec;
                    pc_q    <= dest_q;
                    state_q <= ST_FINISH;
                end
                ST_POP_LO: begin
                    link_q[BW-1:0] <= st_rdata;
                    sp_q           <= sp_inc;
                    state_q        <= ST_POP_HI;
                end
                ST_POP_HI: begin
                    pc_q    <= {st_rdata, link_q[BW-1:0]};
                    sp_q    <= sp_inc;
                    state_q <= ST_FINISH;
                end
                ST_FINISH: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Output drive.
    assign pc   = pc_q;
    assign sp   = sp_q;
    assign done = (state_q == ST_FINISH);

endmodule

// File: rtl/flow_ctl_chk.sv
// Property checker for the branch and stack sequencer, bound into
// every flow_ctl instance. Observes ports plus the busy and flag-test
// signals that separate pieces of logic drive.
module flow_ctl_chk #(
    parameter logic [15:0] PC_INIT = 16'h0000,
    parameter logic [15:0] SP_INIT = 16'h0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [2:0]  op,
    input logic        cond_en,
    input logic [2:0]  cond_sel,
    input logic [15:0] hl,
    input logic [15:0] pc,
    input logic [15:0] sp,
    input logic        done,
    input logic        busy,
    input logic        cond_ok
);

    // R1: reset values
    p_reset_vals_r1: assert property (@(posedge clk)
        !rst_n |=> (pc == PC_INIT) && (sp == SP_INIT) && !done);

    // R3: a failed jump steps over its three bytes
    p_jmp_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == 3'd0 && cond_en && !cond_ok)
        |=> (pc == $past(pc) + 16'd3) && done);

    // R5: the stack pointer moves by one byte per clock at most
    p_sp_unit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sp != $past(sp)) |-> ((sp == $past(sp) + 16'd1) || (sp == $past(sp) - 16'd1)));

    // R6: restart lands on eight times its number
    p_rst_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == 3'd3)
        |=> ##2 (pc == {10'd0, $past(cond_sel, 3), 3'd0}) && done);

    // R7: load from HL in one step
    p_pchl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == 3'd4) |=> (pc == $past(hl)) && done);

    // R9: done is a single-clock pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: nothing moves at the edge that ends the done clock
    p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(pc) && $stable(sp));

    // R10: undefined codes change no state
    p_undef_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op >= 3'd5) |=> $stable(pc) && $stable(sp) && done);

endmodule

bind flow_ctl flow_ctl_chk #(.PC_INIT(PC_INIT), .SP_INIT(SP_INIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .cond_en  (cond_en),
    .cond_sel (cond_sel),
    .hl       (hl),
    .pc       (pc),
    .sp       (sp),
    .done     (done),
    .busy     (busy),
    .cond_ok  (cond_ok)
);

// File: tb/flow_ctl_tb.sv
`timescale 1ns/1ps
module flow_ctl_tb;

    localparam int IDX_W = 5;
    localparam int DEPTH = 1 << IDX_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic        cond_en = 1'b0;
    logic [2:0]  cond_sel = '0;
    logic        flag_s = 1'b0;
    logic        flag_z = 1'b0;
    logic        flag_p = 1'b0;
    logic        flag_cy = 1'b0;
    logic [15:0] target = '0;
    logic [15:0] hl = '0;
    logic [15:0] pc;
    logic [15:0] sp;
    logic        done;

    flow_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond_en(cond_en),
        .cond_sel(cond_sel), .flag_s(flag_s), .flag_z(flag_z), .flag_p(flag_p),
        .flag_cy(flag_cy), .target(target), .hl(hl), .pc(pc), .sp(sp), .done(done)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [15:0] pc;
        logic [15:0] sp;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    int          chk_cnt = 0;
    int          fail_cnt = 0;
    int          cyc = 0;
    logic [15:0] m_pc = 16'h0000;
    logic [15:0] m_sp = 16'h0000;
    logic [7:0]  mstk [DEPTH];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        chk_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            check(1'b0, "WDOG", "watchdog expired", cyc, 20000);
            finish_run();
        end
    end

    // Monitor: compare each completion against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            if (sbq.size() == 0) begin
                check(1'b0, "R9", "unexpected done", 1, 0);
            end else begin
                e = sbq.pop_front();
                check(pc == e.pc, e.tag, "pc", pc, e.pc);
                check(sp == e.sp, e.tag, "sp", sp, e.sp);
            end
        end
    end

    // Driver: model the operation, queue the expectation, run it
    task automatic do_op(input logic [2:0] o, input logic ce, input logic [2:0] cs,
                         input logic fs, input logic fz, input logic fp, input logic fc,
                         input logic [15:0] tg, input logic [15:0] hv,
                         input bit hold, input string tag);
        logic [3:0]  fv;
        bit          ok;
        bit          taken;
        bit          stk;
        logic [15:0] ret;
        logic [7:0]  lo;
        logic [7:0]  hi;
        int          lat;
        exp_t        e;
        fv    = {fs, fp, fc, fz};
        ok    = (fv[cs[2:1]] == cs[0]);
        taken = !ce || ok;
        stk   = 1'b0;
        case (o)
            3'd0: m_pc = taken ? tg : m_pc + 16'd3;
            3'd1, 3'd3: begin
                if (o == 3'd3 || taken) begin
                    ret = (o == 3'd1) ? m_pc + 16'd3 : m_pc + 16'd1;
                    m_sp = m_sp - 16'd1; mstk[m_sp[IDX_W-1:0]] = ret[15:8];
                    m_sp = m_sp - 16'd1; mstk[m_sp[IDX_W-1:0]] = ret[7:0];
                    m_pc = (o == 3'd1) ? tg : {10'd0, cs, 3'd0};
                    stk  = 1'b1;
                end else begin
                    m_pc = m_pc + 16'd3;
                end
            end
            3'd2: begin
                if (taken) begin
                    lo = mstk[m_sp[IDX_W-1:0]]; m_sp = m_sp + 16'd1;
                    hi = mstk[m_sp[IDX_W-1:0]]; m_sp = m_sp + 16'd1;
                    m_pc = {hi, lo};
                    stk  = 1'b1;
                end else begin
                    m_pc = m_pc + 16'd1;
                end
            end
            3'd4: m_pc = hv;
            default: ;
        endcase
        e.pc = m_pc; e.sp = m_sp; e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
        op = o; cond_en = ce; cond_sel = cs; flag_s = fs; flag_z = fz;
        flag_p = fp; flag_cy = fc; target = tg; hl = hv; start = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (!hold) start = 1'b0;
        end while (!done && lat < 10);
        check(lat == (stk ? 3 : 1), tag, "latency", lat, stk ? 3 : 1);
        if (hold) begin
            @(negedge clk);
            start = 1'b0;
            check(!done, "R9", "done after held start", done, 0);
            check(pc == m_pc, "R9", "pc after held start", pc, m_pc);
            check(sp == m_sp, "R9", "sp after held start", sp, m_sp);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(pc == 16'h0000, "R1", "reset pc", pc, 0);
        check(sp == 16'h0000, "R1", "reset sp", sp, 0);
        check(!done, "R1", "reset done", done, 0);
        rst_n = 1'b1;

        // R3 jumps, R2 condition codes
        do_op(3'd0, 0, 3'd0, 0,0,0,0, 16'h1234, 16'h0, 0, "R3 jmp");
        do_op(3'd0, 1, 3'd1, 0,0,0,0, 16'h5555, 16'h0, 0, "R2 jz untaken");
        do_op(3'd0, 1, 3'd3, 0,0,0,1, 16'h2000, 16'h0, 0, "R2 jc taken");
        do_op(3'd0, 1, 3'd2, 0,0,0,1, 16'h7777, 16'h0, 0, "R2 jnc untaken");
        // R4 calls, R8 untaken call
        do_op(3'd1, 0, 3'd0, 0,0,0,0, 16'h3000, 16'h0, 0, "R4 call");
        do_op(3'd1, 1, 3'd5, 0,0,1,0, 16'h4000, 16'h0, 0, "R4 cpe taken");
        do_op(3'd1, 1, 3'd0, 0,1,0,0, 16'h6666, 16'h0, 0, "R8 cnz untaken");
        // R6 restart
        do_op(3'd3, 0, 3'd5, 0,0,0,0, 16'h0, 16'h0, 0, "R6 rst5");
        // R5 returns
        do_op(3'd2, 1, 3'd7, 0,0,0,0, 16'h0, 16'h0, 0, "R5 rm untaken");
        do_op(3'd2, 0, 3'd0, 0,0,0,0, 16'h0, 16'h0, 0, "R5 ret");
        do_op(3'd2, 1, 3'd6, 0,0,0,0, 16'h0, 16'h0, 0, "R5 rp taken");
        do_op(3'd2, 1, 3'd4, 0,0,0,0, 16'h0, 16'h0, 0, "R5 rpo taken");
        // R7 load from HL
        do_op(3'd4, 0, 3'd0, 0,0,0,0, 16'h0, 16'hABCD, 0, "R7 pchl");
        // R10 undefined codes
        do_op(3'd6, 0, 3'd0, 0,0,0,0, 16'h9999, 16'h1111, 0, "R10 op6");
        do_op(3'd7, 1, 3'd3, 0,0,0,1, 16'h9999, 16'h1111, 0, "R10 op7");
        // R9 start held through a whole call
        do_op(3'd1, 0, 3'd0, 0,0,0,0, 16'h5550, 16'h0, 1, "R9 held call");
        do_op(3'd2, 1, 3'd2, 0,0,0,0, 16'h0, 16'h0, 0, "R5 rnc taken");
        // R6 vector boundaries
        do_op(3'd3, 0, 3'd7, 0,0,0,0, 16'h0, 16'h0, 0, "R6 rst7");
        do_op(3'd3, 0, 3'd0, 0,0,0,0, 16'h0, 16'h0, 0, "R6 rst0");
        do_op(3'd2, 0, 3'd0, 0,0,0,0, 16'h0, 16'h0, 0, "R6 ret from rst0");
        do_op(3'd2, 0, 3'd0, 0,0,0,0, 16'h0, 16'h0, 0, "R6 ret from rst7");
        // R11 deep nesting
        for (int k = 0; k < 15; k++)
            do_op(3'd1, 0, 3'd0, 0,0,0,0, 16'h1000 + 16'(k * 32), 16'h0, 0, "R11 nest call");
        for (int k = 0; k < 15; k++)
            do_op(3'd2, 0, 3'd0, 0,0,0,0, 16'h0, 16'h0, 0, "R11 nest ret");
        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "R9", "scoreboard drained", sbq.size(), 0);
        finish_run();
    end

endmodule